// File: doc/BRIEF.md
# Fractional-Period Dead-Time PWM Generator

This block drives two complementary waveforms from one counter. Each output cycle walks through four phases in a fixed order: a dead gap before output A, the high time of A, a dead gap before output B, and the high time of B. Output A is high only in its own high phase and output B only in its own, so the two are never high together. Each phase length is a whole number of clocks.

A fractional value in sixteenths of a clock is added to an error accumulator at the start of every cycle. When that sum passes one whole clock, the cycle taking the carry stretches its selected phases by one clock. The average period can then sit between integers. A ramp-mode select decides whether a stretched phase also lengthens the cycle or whether the next phase gives the clock back. One mode rejects dithering altogether.

All pins are plain level controls. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The settings are sampled only when a new cycle begins.

Top module: `dither_pwm_gen`

## Requirements
- R1: Each active cycle runs dead-A, on-A, dead-B, on-B in that order, each lasting its programmed length in clocks; a programmed length of 0 counts as 1. `pwm_a` is high exactly during on-A and `pwm_b` exactly during on-B.
- R2: `cyc_start` is high for exactly one clock, the first clock of dead-A of every cycle.
- R3: While `en` is low both outputs and `cyc_start` stay low; the edge that samples `en` high after idle starts a cycle, so `cyc_start` is seen one clock after `en` is raised, and the edge that samples `en` low ends any cycle at once.
- R4: At each cycle start the 4-bit accumulator adds `frac` (sixteenths). If the sum reaches 16 there is a carry for that cycle, and the accumulator keeps the sum minus 16.
- R5: `tgt_sel` encodings: 0 = stretch on-B, 1 = stretch on-A and on-B, 2 = stretch dead-B, 3 = stretch dead-A and dead-B.
- R6: `ramp_sel` = 0 (one-ramp): only the on-B phase extends the cycle; a carry makes the cycle 1 clock longer for targets 0 and 1 and leaves it unchanged for targets 2 and 3.
- R7: `ramp_sel` = 1 (two-ramp): on-A and on-B extend the cycle; a carry adds 1 clock for target 0, 2 for target 1, 0 for targets 2 and 3.
- R8: `ramp_sel` = 2 (four-ramp): every phase extends the cycle; a carry adds 1 clock for targets 0 and 2 and 2 clocks for targets 1 and 3.
- R9: `ramp_sel` = 3 (dual-slope): carries are ignored and every phase keeps its programmed length.
- R10: A stretched phase that does not extend the cycle in the current mode makes the following phase one clock shorter, but never shorter than 1 clock.
- R11: Lengths, `frac`, `tgt_sel` and `ramp_sel` are taken only at a cycle start; a change made mid-cycle first shows in the next cycle.
- R12: Reset clears the accumulator and holds both outputs and `cyc_start` low.
- R13: After reset, with phases summing to 133 clocks, `frac` = 5 and target on-B in one-ramp mode, exactly 5 of the first 16 cycles last 134 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| len_dead_a | input | LEN_W | Dead gap before A, in clocks |
| len_on_a | input | LEN_W | High time of A, in clocks |
| len_dead_b | input | LEN_W | Dead gap before B, in clocks |
| len_on_b | input | LEN_W | High time of B, in clocks |
| frac | input | FRAC_W | Fractional period error per cycle, in 1/16 clock |
| tgt_sel | input | 2 | Phase(s) stretched on a carry |
| ramp_sel | input | 2 | Ramp mode |
| pwm_a | output | 1 | Waveform A |
| pwm_b | output | 1 | Waveform B |
| cyc_start | output | 1 | One-clock strobe at each cycle start |

## Verification
A corrupted accumulator does not show up at once. It surfaces as a carry landing in the wrong cycle, so the first bad cycle can come up to sixteen cycles later, and only as a single phase one clock too long or too short. For that reason every phase width of every cycle is measured and compared with a model. A wrong ramp-mode or target decode shows within the first carried cycle, as a misplaced stretch or a missing shortening. A sequencer fault changes a phase width within one cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  typedef enum logic [1:0] {
    PH_DEAD_A = 2'd0,
    PH_ON_A   = 2'd1,
    PH_DEAD_B = 2'd2,
    PH_ON_B   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    RAMP_ONE  = 2'd0,
    RAMP_TWO  = 2'd1,
    RAMP_FOUR = 2'd2,
    RAMP_DUAL = 2'd3
  } ramp_e;

  // Is phase ph one of the phases stretched by target code tgt?
  function automatic logic targeted(input logic [1:0] tgt, input int unsigned ph);
    case (tgt)
      2'd0:    return ph == 3;
      2'd1:    return (ph == 1) || (ph == 3);
      2'd2:    return ph == 2;
      default: return (ph == 0) || (ph == 2);
    endcase
  endfunction

  // Does stretching phase ph lengthen the whole cycle in ramp mode?
  function automatic logic extends_cycle(input logic [1:0] mode, input int unsigned ph);
    case (mode)
      2'd0:    return ph == 3;
      2'd1:    return (ph == 1) || (ph == 3);
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dpwm_frac_accum.sv
module dpwm_frac_accum #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, frac};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= sum[FRAC_W-1:0];
  end

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q));

  // R4
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && carry) |=> (acc_q < $past(frac)));

  // R4
  no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !carry) |=> (acc_q >= $past(frac)));
endmodule

// File: rtl/dpwm_len_shaper.sv
module dpwm_len_shaper #(
  parameter int LEN_W = 8,
  parameter int NPH   = 4,
  localparam int EW   = LEN_W + 1,
  localparam int TW   = EW + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPH-1:0][LEN_W-1:0] len_in,
  input  logic                      carry,
  input  logic [1:0]                tgt,
  input  logic [1:0]                mode,
  output logic [NPH-1:0][EW-1:0]    len_eff
);
  import dpwm_pkg::*;

  logic                    dither_on;
  logic [NPH-1:0]          grow_v;
  logic [NPH-1:0][EW-1:0]  base_v;
  logic [TW-1:0]           total_base, total_eff;

  assign dither_on = carry && (ramp_e'(mode) != RAMP_DUAL);

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic          shrink;
    logic [EW-1:0] grown;

    assign base_v[p] = (len_in[p] == '0) ? EW'(1) : EW'(len_in[p]);
    assign grow_v[p] = dither_on && targeted(tgt, p);
    assign grown     = base_v[p] + EW'(grow_v[p]);

    if (p == 0) begin : g_first
      assign shrink = 1'b0;
    end else begin : g_rest
      assign shrink = grow_v[p-1] && !extends_cycle(mode, p - 1);
    end

    assign len_eff[p] = (shrink && (grown > EW'(1))) ? grown - EW'(1) : grown;

    // R10
    phase_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_eff[p] != '0);
  end

  always_comb begin
    total_base = '0;
    total_eff  = '0;
    for (int i = 0; i < NPH; i++) begin
      total_base = total_base + TW'(base_v[i]);
      total_eff  = total_eff + TW'(len_eff[i]);
    end
  end

  // R9
  dual_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_e'(mode) == RAMP_DUAL) |-> (total_eff == total_base));

  // R8
  growth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (total_eff >= total_base) && (total_eff <= total_base + TW'(2)));
endmodule

// File: rtl/dpwm_phase_seq.sv
module dpwm_phase_seq #(
  parameter int EW  = 9,
  parameter int NPH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [NPH-1:0][EW-1:0] len_eff,
  output logic                   take,
  output logic                   active,
  output dpwm_pkg::phase_e       phase,
  output logic                   first_clk
);
  import dpwm_pkg::*;

  logic                   act_q;
  phase_e                 ph_q;
  logic [EW-1:0]          cnt_q;
  logic [NPH-1:0][EW-1:0] len_q;
  logic                   at_end, last;

  assign at_end = (cnt_q == len_q[ph_q] - EW'(1));
  assign last   = act_q && (ph_q == PH_ON_B) && at_end;
  assign take   = en && (!act_q || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= PH_DEAD_A;
      cnt_q <= '0;
      len_q <= '0;
    end else if (!en) begin
      act_q <= 1'b0;
      ph_q  <= PH_DEAD_A;
      cnt_q <= '0;
    end else if (take) begin
      act_q <= 1'b1;
      ph_q  <= PH_DEAD_A;
      cnt_q <= '0;
      len_q <= len_eff;
    end else if (at_end) begin
      ph_q  <= phase_e'(ph_q + 2'd1);
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + EW'(1);
    end
  end

  assign active    = act_q;
  assign phase     = ph_q;
  assign first_clk = (cnt_q == '0);

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !act_q);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < len_q[ph_q]));

  // R11
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !take) |=> $stable(len_q));
endmodule

// File: rtl/dither_pwm_gen.sv
module dither_pwm_gen #(
  parameter int LEN_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [LEN_W-1:0]  len_dead_a,
  input  logic [LEN_W-1:0]  len_on_a,
  input  logic [LEN_W-1:0]  len_dead_b,
  input  logic [LEN_W-1:0]  len_on_b,
  input  logic [FRAC_W-1:0] frac,
  input  logic [1:0]        tgt_sel,
  input  logic [1:0]        ramp_sel,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              cyc_start
);
  import dpwm_pkg::*;

  localparam int NPH = 4;
  localparam int EW  = LEN_W + 1;

  logic [NPH-1:0][LEN_W-1:0] len_pack;
  logic [NPH-1:0][EW-1:0]    len_eff;
  logic                      take, carry, active, first_clk;
  phase_e                    phase;

  assign len_pack = {len_on_b, len_dead_b, len_on_a, len_dead_a};

  dpwm_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (take),
    .frac  (frac),
    .carry (carry)
  );

  dpwm_len_shaper #(.LEN_W(LEN_W), .NPH(NPH)) u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .len_in  (len_pack),
    .carry   (carry),
    .tgt     (tgt_sel),
    .mode    (ramp_sel),
    .len_eff (len_eff)
  );

  dpwm_phase_seq #(.EW(EW), .NPH(NPH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .len_eff   (len_eff),
    .take      (take),
    .active    (active),
    .phase     (phase),
    .first_clk (first_clk)
  );

  assign pwm_a     = active && (phase == PH_ON_A);
  assign pwm_b     = active && (phase == PH_ON_B);
  assign cyc_start = active && (phase == PH_DEAD_A) && first_clk;

  // R1
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_a) |-> !pwm_b);

  // R2
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);
endmodule

// File: tb/dither_pwm_gen_test.sv
`timescale 1ns/1ps
module dither_pwm_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] l_da = 8'd1, l_oa = 8'd1, l_db = 8'd1, l_ob = 8'd1;
  logic [3:0] frac = 4'd0;
  logic [1:0] tgt = 2'd0, mode = 2'd0;
  logic       pwm_a, pwm_b, cyc_start;

  always #4 clk = ~clk;

  dither_pwm_gen #(.LEN_W(8), .FRAC_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .len_dead_a(l_da), .len_on_a(l_oa), .len_dead_b(l_db), .len_on_b(l_ob),
    .frac(frac), .tgt_sel(tgt), .ramp_sel(mode),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .cyc_start(cyc_start)
  );

  typedef struct { int w[4]; } item_t;
  item_t exp_q[$];

  int    checks = 0, errors = 0;
  int    b_acc = 0;
  int    starts = 0, long_seen = 0;
  bit    inprog = 0;
  int    m[4];
  int    seg = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Model of one cycle from the requirements; advances the bench accumulator.
  function automatic item_t model_step(input int l0, l1, l2, l3);
    item_t it;
    int    lens[4];
    bit    grow[4];
    bit    cy, sel, ext;
    int    sum;
    lens = '{l0, l1, l2, l3};
    sum = b_acc + int'(frac);
    cy = (sum >= 16);
    b_acc = sum % 16;
    for (int p = 0; p < 4; p++) begin
      case (tgt)
        2'd0: sel = (p == 3);
        2'd1: sel = (p == 1) || (p == 3);
        2'd2: sel = (p == 2);
        default: sel = (p == 0) || (p == 2);
      endcase
      grow[p] = cy && (mode != 2'd3) && sel;
      it.w[p] = ((lens[p] == 0) ? 1 : lens[p]) + (grow[p] ? 1 : 0);
    end
    for (int p = 1; p < 4; p++) begin
      case (mode)
        2'd0: ext = (p - 1 == 3);
        2'd1: ext = (p - 1 == 1) || (p - 1 == 3);
        2'd2: ext = 1'b1;
        default: ext = 1'b0;
      endcase
      if (grow[p-1] && !ext && it.w[p] > 1) it.w[p] = it.w[p] - 1;
    end
    return it;
  endfunction

  // Monitor: measures each completed cycle and pops the expected item.
  always @(negedge clk) begin
    if (!rst_n) begin
      inprog = 0;
    end else begin
      if (cyc_start) begin
        starts++;
        if (inprog) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, 1, 0);
          end else begin
            item_t e;
            e = exp_q.pop_front();
            for (int p = 0; p < 4; p++) chk(m[p] == e.w[p], cur_req, m[p], e.w[p]);
            if (m[0] + m[1] + m[2] + m[3] == 134) long_seen++;
          end
        end
        m = '{0, 0, 0, 0};
        seg = 0;
        inprog = 1;
      end
      if (inprog) begin
        if (pwm_a) begin m[1]++; seg = 1; end
        else if (pwm_b) begin m[3]++; seg = 3; end
        else if (seg == 0) m[0]++;
        else m[2]++;
      end
    end
  end

  task automatic set_cfg(input int a, b, c, d, input int fr, tg, md);
    l_da = 8'(a); l_oa = 8'(b); l_db = 8'(c); l_ob = 8'(d);
    frac = 4'(fr); tgt = 2'(tg); mode = 2'(md);
  endtask

  task automatic finish_run(input int s0, input int n);
    while (starts < s0 + n + 1) @(posedge clk);
    #1 en = 1'b0;
    inprog = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, cur_req, exp_q.size(), 0);
  endtask

  task automatic run_cfg(input int a, b, c, d, input int fr, tg, md, input int n, input string req);
    int s0;
    @(posedge clk); #1;
    cur_req = req;
    set_cfg(a, b, c, d, fr, tg, md);
    for (int i = 0; i < n; i++) exp_q.push_back(model_step(a, b, c, d));
    void'(model_step(a, b, c, d));
    s0 = starts;
    en = 1'b1;
    @(negedge clk);
    chk(cyc_start == 1'b0, "R3", cyc_start, 0);
    @(negedge clk);
    chk(cyc_start == 1'b1, "R2", cyc_start, 1);
    finish_run(s0, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(pwm_a == 1'b0, "R12", pwm_a, 0);
    chk(pwm_b == 1'b0, "R12", pwm_b, 0);
    chk(cyc_start == 1'b0, "R12", cyc_start, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 R2 plain cycles, no carry
    run_cfg(3, 4, 2, 5, 0, 0, 0, 4, "R1");
    // R3 outputs stay low while disabled
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!pwm_a && !pwm_b && !cyc_start, "R3", {pwm_a, pwm_b, cyc_start}, 0);
    end
    // R4 R5 R6 one-ramp, on-B target
    run_cfg(3, 4, 2, 5, 6, 0, 0, 8, "R6");
    // R6 R10 one-ramp, on-A and on-B
    run_cfg(3, 4, 3, 5, 9, 1, 0, 8, "R6");
    // R10 one-ramp, dead-time targets
    run_cfg(3, 4, 3, 5, 11, 3, 0, 8, "R10");
    run_cfg(2, 3, 2, 4, 10, 2, 0, 6, "R10");
    // R7 two-ramp
    run_cfg(3, 4, 3, 5, 7, 1, 1, 8, "R7");
    run_cfg(3, 4, 3, 5, 8, 2, 1, 6, "R7");
    // R8 four-ramp
    run_cfg(3, 4, 3, 5, 12, 3, 2, 8, "R8");
    run_cfg(3, 4, 3, 5, 13, 2, 2, 6, "R8");
    // R9 dual-slope ignores carries
    run_cfg(3, 4, 3, 5, 15, 1, 3, 8, "R9");
    // R1 zero lengths count as one; R10 floor at one
    run_cfg(0, 2, 0, 3, 14, 3, 0, 6, "R1");
    run_cfg(1, 1, 1, 1, 14, 3, 1, 6, "R10");

    // R11 mid-cycle change takes effect at the next cycle
    begin
      int s0;
      @(posedge clk); #1;
      cur_req = "R11";
      set_cfg(4, 3, 4, 3, 0, 0, 0);
      exp_q.push_back(model_step(4, 3, 4, 3));
      for (int i = 0; i < 2; i++) exp_q.push_back(model_step(2, 5, 2, 6));
      void'(model_step(2, 5, 2, 6));
      s0 = starts;
      en = 1'b1;
      while (starts < s0 + 1) @(posedge clk);
      repeat (2) @(posedge clk);
      #1 set_cfg(2, 5, 2, 6, 0, 0, 0);
      finish_run(s0, 3);
    end

    // R12 reset clears the accumulator
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk(!pwm_a && !pwm_b && !cyc_start, "R12", {pwm_a, pwm_b, cyc_start}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    b_acc = 0;

    // R13 long-run average over 16 cycles of 133 + 5/16
    long_seen = 0;
    run_cfg(30, 40, 23, 40, 5, 0, 0, 16, "R13");
    chk(long_seen == 5, "R13", long_seen, 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule